// File: doc/BRIEF.md
# Counter-Form Predicate Decoder

This block turns a 16-bit predicate held in counter form into the three values a vector unit needs to walk its elements in order: how many leading elements are active, the log2 step between consumed elements, and whether the sense of the predicate is inverted. A unit that processes elements one after another can use these values directly and never has to build a per-element bit mask.

The low bits of the encoding carry the predicate's own element size as a position marker. The bits above the marker carry the count. When the size the predicate was written for differs from the element size of the vector operation, the count is corrected here. If the predicate elements are narrower, the count is rounded up. If they are wider, the count is scaled up and a skip stride is produced. The vector length in bytes limits how many encoding bits count. A length that is not a power of two is first rounded up to the next power of two.

The decode is registered. The caller pulses a strobe with the inputs. A valid pulse comes back one cycle later, and the result stays on the outputs until the next strobe.

Top module: `predCounterDecode`

## Requirements
- R1: While reset is asserted and after it is released, and before the first strobe, `outValid`, `elemCount`, `strideLog2` and `invertFlag` are all zero.
- R2: A strobe sampled at a rising edge raises `outValid` for exactly one cycle after that edge. `outValid` is low in every cycle not preceded by a strobe. The count, stride and invert outputs keep their values until the next strobe.
- R3: If bits [3:0] of the encoding are all zero, the count, stride and invert outputs are all zero.
- R4: Otherwise `invertFlag` equals bit 15 of the encoding.
- R5: Size codes 0, 1, 2 and 3 mean 8-, 16-, 32- and 64-bit elements. The predicate size code is the number of trailing zero bits of the encoding. The raw count is (encoding AND (L*8 - 1)) shifted right by (predicate size + 1), where L is the vector length in bytes rounded up to a power of two. When the predicate size equals the vector element size, the count is the raw count and the stride is 0.
- R6: A vector length (16 to 256 bytes) that is not a power of two is treated as the next power of two. For example, 48 acts as 64 and masks the encoding with 511.
- R7: When the predicate size is smaller than the vector element size, the count is the raw count divided by 2^(difference), rounded up, and the stride is 0.
- R8: When the predicate size is larger than the vector element size, the count is the raw count times 2^(difference) and the stride equals the difference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inStrobe | input | 1 | Capture the inputs and start a decode |
| predEnc | input | 16 | Counter-form predicate encoding |
| vecLenBytes | input | 9 | Vector length in bytes, 16 to 256 |
| vecElemSize | input | 2 | Element size code of the vector operation |
| outValid | output | 1 | One-cycle pulse marking a new result |
| elemCount | output | 16 | Active element count |
| strideLog2 | output | 2 | Log2 of the element stride |
| invertFlag | output | 1 | Predicate sense inverted |

## Verification
Encodings with a zero low nibble but bit 15 set show that the inactive case wins over the invert bit. Encodings with marker positions 0 to 3 are each decoded against all four vector element sizes. These tell rounding-up, pass-through and scale-with-stride apart, and raw counts that are not multiples of the size gap expose a truncating divide. The same encoding is decoded under a power-of-two length and under a length just above a power of two (48 against 32, 100 against 128). This shows whether the mask tracks the rounded length. Idle cycles after a result confirm that the outputs hold and that no extra valid pulse appears.

// File: rtl/pcdPkg.sv
package pcdPkg;
  // Strobes passed from control to datapath
  typedef struct packed {
    logic capture;
  } pcdStrobes_t;
endpackage

// File: rtl/pcdPow2Ceil.sv
module pcdPow2Ceil #(
  parameter int VL_W = 9
) (
  input  logic [VL_W-1:0] lenBytes,
  output logic [VL_W:0]   lenCeil
);
  logic [VL_W-1:0] lenLess;
  logic [VL_W-1:0] topBit;

  assign lenLess = lenBytes - VL_W'(1);

  // Priority encoder: flag only the highest set bit of (length - 1)
  genvar g;
  generate
    for (g = 0; g < VL_W; g++) begin : g_top
      if (g == VL_W - 1) begin : g_msb
        assign topBit[g] = lenLess[g];
      end else begin : g_low
        assign topBit[g] = lenLess[g] & ~(|lenLess[VL_W-1:g+1]);
      end
    end
  endgenerate

  assign lenCeil = (lenLess == '0) ? (VL_W+1)'(1) : {topBit, 1'b0};
endmodule

// File: rtl/pcdCtrl.sv
module pcdCtrl
  import pcdPkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        inStrobe,
  output pcdStrobes_t strb,
  output logic        outValid
);
  assign strb.capture = inStrobe;

  always_ff @(posedge clk) begin
    if (!rst_n) outValid <= 1'b0;
    else        outValid <= inStrobe;
  end

  // R2
  valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inStrobe |=> outValid);
  // R2
  valid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !inStrobe |=> !outValid);
endmodule

// File: rtl/pcdDatapath.sv
module pcdDatapath
  import pcdPkg::*;
#(
  parameter int ENC_W = 16,
  parameter int VL_W  = 9,
  parameter int CNT_W = 16,
  parameter int ESZ_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  pcdStrobes_t       strb,
  input  logic [ENC_W-1:0]  predEnc,
  input  logic [VL_W-1:0]   vecLenBytes,
  input  logic [ESZ_W-1:0]  vecElemSize,
  output logic [CNT_W-1:0]  elemCount,
  output logic [ESZ_W-1:0]  strideLog2,
  output logic              invertFlag
);
  localparam int SZ_N   = 1 << ESZ_W;
  localparam int CEIL_W = VL_W + 1;
  localparam int MASK_W = CEIL_W + 3;
  localparam int WIDE_W = (MASK_W > ENC_W) ? MASK_W : ENC_W;

  logic [CEIL_W-1:0] lenCeil;
  logic              sizeSeen;
  logic [ESZ_W-1:0]  predSize;
  logic [WIDE_W-1:0] lenMask;
  logic [WIDE_W-1:0] maskedEnc;
  logic [WIDE_W-1:0] rawWide;
  logic [CNT_W-1:0]  rawCnt;
  logic [ESZ_W-1:0]  sizeGap;
  logic [CNT_W-1:0]  truncCnt;
  logic [CNT_W-1:0]  adjCnt;
  logic [ESZ_W-1:0]  adjStride;
  logic              invNext;

  pcdPow2Ceil #(.VL_W(VL_W)) ceilU (
    .lenBytes (vecLenBytes),
    .lenCeil  (lenCeil)
  );

  // Trailing-zero count over the size marker field
  always_comb begin
    predSize = '0;
    for (int i = SZ_N - 1; i >= 0; i--) begin
      if (predEnc[i]) predSize = ESZ_W'(i);
    end
  end
  assign sizeSeen = |predEnc[SZ_N-1:0];

  // Raw count: mask by rounded length, drop marker and the bits below it
  assign lenMask   = WIDE_W'({lenCeil, 3'b000}) - WIDE_W'(1);
  assign maskedEnc = WIDE_W'(predEnc) & lenMask;
  assign rawWide   = maskedEnc >> ({1'b0, predSize} + (ESZ_W+1)'(1));
  assign rawCnt    = CNT_W'(rawWide);

  // Size mismatch correction
  always_comb begin
    adjCnt    = rawCnt;
    adjStride = '0;
    truncCnt  = rawCnt;
    sizeGap   = '0;
    if (predSize < vecElemSize) begin
      sizeGap  = vecElemSize - predSize;
      truncCnt = rawCnt >> sizeGap;
      adjCnt   = truncCnt + CNT_W'((truncCnt << sizeGap) != rawCnt);
    end else if (predSize > vecElemSize) begin
      sizeGap   = predSize - vecElemSize;
      adjCnt    = rawCnt << sizeGap;
      adjStride = sizeGap;
    end
    if (!sizeSeen) begin
      adjCnt    = '0;
      adjStride = '0;
    end
  end

  assign invNext = sizeSeen & predEnc[ENC_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      elemCount  <= '0;
      strideLog2 <= '0;
      invertFlag <= 1'b0;
    end else if (strb.capture) begin
      elemCount  <= adjCnt;
      strideLog2 <= adjStride;
      invertFlag <= invNext;
    end
  end

  // R3
  zero_marker_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.capture && (predEnc[SZ_N-1:0] == '0)
    |=> (elemCount == '0) && (strideLog2 == '0) && !invertFlag);
  // R4
  invert_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.capture && (predEnc[SZ_N-1:0] != '0)
    |=> invertFlag == $past(predEnc[ENC_W-1]));
  // R7
  narrow_no_stride_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.capture && predEnc[0] |=> strideLog2 == '0);
  // R8
  stride_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((elemCount >> strideLog2) << strideLog2) == elemCount);
  // R2
  hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.capture |=> $stable(elemCount) && $stable(strideLog2) && $stable(invertFlag));
  // R6
  ceil_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(lenCeil) == 1);
  // R6
  ceil_covers_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vecLenBytes != '0) |-> ({1'b0, vecLenBytes} <= lenCeil));
endmodule

// File: rtl/predCounterDecode.sv
module predCounterDecode
  import pcdPkg::*;
#(
  parameter int ENC_W = 16,
  parameter int VL_W  = 9,
  parameter int CNT_W = 16,
  parameter int ESZ_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inStrobe,
  input  logic [ENC_W-1:0] predEnc,
  input  logic [VL_W-1:0]  vecLenBytes,
  input  logic [ESZ_W-1:0] vecElemSize,
  output logic             outValid,
  output logic [CNT_W-1:0] elemCount,
  output logic [ESZ_W-1:0] strideLog2,
  output logic             invertFlag
);
  pcdStrobes_t strb;

  pcdCtrl ctrlU (
    .clk      (clk),
    .rst_n    (rst_n),
    .inStrobe (inStrobe),
    .strb     (strb),
    .outValid (outValid)
  );

  pcdDatapath #(
    .ENC_W (ENC_W),
    .VL_W  (VL_W),
    .CNT_W (CNT_W),
    .ESZ_W (ESZ_W)
  ) dpU (
    .clk         (clk),
    .rst_n       (rst_n),
    .strb        (strb),
    .predEnc     (predEnc),
    .vecLenBytes (vecLenBytes),
    .vecElemSize (vecElemSize),
    .elemCount   (elemCount),
    .strideLog2  (strideLog2),
    .invertFlag  (invertFlag)
  );
endmodule

// File: tb/predCounterDecode_test.sv
module predCounterDecode_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inStrobe = 1'b0;
  logic [15:0] predEnc = '0;
  logic [8:0]  vecLenBytes = 9'd16;
  logic [1:0]  vecElemSize = '0;
  logic        outValid;
  logic [15:0] elemCount;
  logic [1:0]  strideLog2;
  logic        invertFlag;

  int totalChecks = 0;
  int failChecks = 0;

  typedef struct {
    int    cnt;
    int    str;
    int    inv;
    string tag;
  } expItem_t;

  expItem_t scoreQ[$];
  expItem_t lastExp;

  always #2.5 clk = ~clk;

  predCounterDecode uut (
    .clk(clk), .rst_n(rst_n), .inStrobe(inStrobe), .predEnc(predEnc),
    .vecLenBytes(vecLenBytes), .vecElemSize(vecElemSize), .outValid(outValid),
    .elemCount(elemCount), .strideLog2(strideLog2), .invertFlag(invertFlag)
  );

  function automatic expItem_t model(logic [15:0] enc, int vl, int vsz, string tag);
    expItem_t e;
    int ceilv;
    int p;
    int raw;
    int d;
    e.tag = tag; e.cnt = 0; e.str = 0; e.inv = 0;
    if (enc[3:0] == 4'b0) return e;
    ceilv = 1;
    while (ceilv < vl) ceilv = ceilv * 2;
    p = 0;
    while (enc[p] == 1'b0) p++;
    raw = (int'(enc) & (ceilv * 8 - 1)) >> (p + 1);
    if (p < vsz) begin
      d = vsz - p;
      e.cnt = (raw + (1 << d) - 1) >> d;
    end else if (p > vsz) begin
      d = p - vsz;
      e.cnt = raw << d;
      e.str = d;
    end else begin
      e.cnt = raw;
    end
    e.inv = int'(enc[15]);
    return e;
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    totalChecks++;
    if (!ok) begin
      failChecks++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic send(logic [15:0] enc, int vl, int vsz, string tag);
    @(negedge clk);
    predEnc     = enc;
    vecLenBytes = 9'(vl);
    vecElemSize = 2'(vsz);
    inStrobe    = 1'b1;
    lastExp     = model(enc, vl, vsz, tag);
    scoreQ.push_back(lastExp);
    @(negedge clk);
    inStrobe = 1'b0;
  endtask

  // Monitor: pop one expected item per valid pulse
  always @(negedge clk) begin
    if (rst_n && outValid) begin
      if (scoreQ.size() == 0) begin
        check(1'b0, "R2", "spurious valid", 1, 0);
      end else begin
        expItem_t e;
        e = scoreQ.pop_front();
        check(int'(elemCount) == e.cnt, e.tag, "count", int'(elemCount), e.cnt);
        check(int'(strideLog2) == e.str, e.tag, "stride", int'(strideLog2), e.str);
        check(int'(invertFlag) == e.inv, e.tag, "invert", int'(invertFlag), e.inv);
      end
    end
  end

  task automatic finishRun();
    $display("%0d/%0d checks passed", totalChecks - failChecks, totalChecks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "WATCHDOG", "timeout", 0, 1);
    finishRun();
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    check(outValid == 1'b0, "R1", "valid in reset", int'(outValid), 0);
    check(elemCount == '0, "R1", "count in reset", int'(elemCount), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(outValid == 1'b0 && strideLog2 == '0 && invertFlag == 1'b0,
          "R1", "idle after reset", int'(outValid), 0);

    // R3 zero marker beats invert bit
    send(16'h8000, 16, 0, "R3");
    send(16'hFFF0, 256, 3, "R3");
    // R4 / R5 matched sizes
    send(16'h8013, 16, 0, "R4");
    send(16'h0013, 16, 0, "R5");
    send(16'h00A2, 64, 1, "R5");
    // R7 narrower predicate, rounding up
    send(16'h8013, 16, 2, "R7");
    send(16'h0031, 32, 3, "R7");
    // R8 wider predicate
    send(16'h0048, 32, 0, "R8");
    send(16'h0ABC, 256, 1, "R8");
    // R6 non-power-of-two lengths
    send(16'h01F2, 48, 1, "R6");
    send(16'h01F2, 32, 1, "R6");
    send(16'h07F1, 100, 0, "R6");
    send(16'h07F1, 128, 0, "R6");

    // R2 hold and no extra valid
    repeat (2) @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(outValid == 1'b0, "R2", "valid idle", int'(outValid), 0);
      check(int'(elemCount) == lastExp.cnt, "R2", "count held", int'(elemCount), lastExp.cnt);
    end

    // Sweep marker positions against every vector size
    for (int m = 0; m < 4; m++) begin
      for (int v = 0; v < 4; v++) begin
        logic [15:0] enc;
        enc = (16'hB5A7 << m) | (16'h1 << m);
        enc = enc & ~((16'h1 << m) - 16'h1);
        send(enc, (m % 2 == 0) ? 80 : 256, v,
             (m < v) ? "R7" : ((m > v) ? "R8" : "R5"));
      end
    end

    repeat (4) @(negedge clk);
    check(scoreQ.size() == 0, "R2", "missing results", scoreQ.size(), 0);
    finishRun();
  end
endmodule